// File: doc/BRIEF.md
# Size-Change Admission Guard for a Variable-Length Transform Pipeline

This block sits at the input of a transform pipeline whose frame length can change from one frame to the next. Smaller frames skip stages and so reach the output sooner than larger ones. If a short frame follows a long one too closely, its first results leave the pipeline before the tail of the long frame has drained, and the output stream is corrupted. The guard follows every frame as it enters, one beat per valid cycle, and remembers the size and latency of the frame that ended last. From these it works out whether a frame start of the size now presented on the size input could safely enter in this cycle.

Each beat carries 2^M samples, so a frame of size code s (2^s points) takes 2^(s-M) valid cycles. The pipeline latency for size s is modelled as a base latency plus a fixed cost for each stage that is not skipped, which gives BASE_LAT + STAGE_LAT*(s-M). When the size drops, the next frame must wait the difference in latency, counted from the last beat of the frame before it. When the size stays the same or grows, frames may follow back to back. The upstream source presents the size of its next frame, waits for `start_ok`, and then raises valid with the start marker. A frame start that is not admitted sets a sticky error flag. The latency of the most recently started frame is presented for use by downstream alignment logic.

Top module: `shg_admission_guard`

## Requirements
- R1: A frame starts on a cycle with `in_valid` and `in_sop` both high and an in-range size code s. It ends on its 2^(s-M)-th valid beat, counting the start beat. Cycles with `in_valid` low are not counted.
- R2: One cycle after a frame starts with size code s, `lat_out` equals BASE_LAT + STAGE_LAT*(s-M). It holds that value until the next frame start. With the defaults (M=1, BASE_LAT=5, STAGE_LAT=3) this gives 8, 11, 14, 17 and 20 for sizes 2 to 6.
- R3: When the presented size is equal to or larger than the size of the frame that ended last, `start_ok` is high in the cycle right after that frame's last beat.
- R4: When the presented size s_new is smaller than the size s_prev of the frame that ended last, `start_ok` stays low for the first L(s_prev)-L(s_new) cycles after that frame's last beat, and goes high in the cycle after those.
- R5: `start_ok` is low in every cycle in which a started frame still has beats to come.
- R6: A cycle with `in_valid` and `in_sop` high while `start_ok` is low sets `hazard` in the next cycle. `hazard` then stays high until reset.
- R7: A size code outside MIN_SIZE..MAX_SIZE (0, 1 and 7 with the defaults) holds `start_ok` low. A start with such a code sets `hazard`, does not start a frame and leaves `lat_out` unchanged.
- R8: Synchronous reset clears `hazard`, sets `lat_out` to 0, and forgets both the frame in flight and the frame that ended last. After reset, any in-range size is admitted.
- R9: `in_sop` with `in_valid` low has no effect: no frame starts, and `start_ok` and `lat_out` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid, held high for the whole of a frame |
| in_sop | input | 1 | First beat of a frame |
| in_size | input | SIZE_W | Size code of the frame being started or about to start (2^code points) |
| start_ok | output | 1 | A frame of the presented size may start in this cycle |
| lat_out | output | LAT_W | Pipeline latency of the most recently started frame |
| hazard | output | 1 | Sticky: a frame start was made that was not admitted |

## Verification
The assertions take for granted only that reset is asserted before the first check and that inputs settle between clock edges. They make no assumption that the source obeys `start_ok`, because rule violations are exactly what the guard must report. The elapsed-time property assumes that the gap counter saturates at the largest possible latency difference. The stimulus walks sizes up and down, including a wait that ends exactly at the required gap. Violations are placed only in marked sections that end in a reset, so the expected sticky flag stays accurate for every cycle.

// File: rtl/shg_pkg.sv
package shg_pkg;

  // Pipeline latency for a size code: base plus one step per active stage.
  function automatic int lat_for_size(input int base, input int step,
                                      input int m, input int size_code);
    return base + step * (size_code - m);
  endfunction

  // Largest gap ever required (largest minus smallest latency).
  function automatic int max_gap(input int step, input int min_size,
                                 input int max_size);
    return step * (max_size - min_size);
  endfunction

endpackage

// File: rtl/shg_lat_table.sv
module shg_lat_table
  import shg_pkg::*;
#(
  parameter int M         = 1,
  parameter int MIN_SIZE  = 2,
  parameter int MAX_SIZE  = 6,
  parameter int BASE_LAT  = 5,
  parameter int STAGE_LAT = 3,
  parameter int SIZE_W    = 3,
  parameter int LAT_W     = 5
) (
  input  logic [SIZE_W-1:0] size_code,
  output logic [LAT_W-1:0]  lat
);

  localparam int ENTRIES = MAX_SIZE + 1;

  logic [LAT_W-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    if (g >= MIN_SIZE) begin : g_valid
      assign tbl[g] = LAT_W'(lat_for_size(BASE_LAT, STAGE_LAT, M, g));
    end else begin : g_unused
      assign tbl[g] = '0;
    end
  end

  always_comb begin
    lat = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (size_code == SIZE_W'(i)) lat = tbl[i];
    end
  end

endmodule

// File: rtl/shg_frame_tracker.sv
module shg_frame_tracker #(
  parameter int M        = 1,
  parameter int MIN_SIZE = 2,
  parameter int MAX_SIZE = 6,
  parameter int SIZE_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              frame_start,
  input  logic [SIZE_W-1:0] in_size,
  output logic              busy,
  output logic              last_beat,
  output logic [SIZE_W-1:0] end_size
);

  localparam int BEAT_W = MAX_SIZE - M + 1;

  logic [BEAT_W-1:0] remain_q;
  logic [SIZE_W-1:0] cur_size_q;
  logic [BEAT_W-1:0] start_len;
  logic              beat;

  assign start_len = BEAT_W'(1) << (in_size - SIZE_W'(M));
  assign busy      = (remain_q != '0);
  assign beat      = in_valid && !frame_start && busy;
  assign last_beat = (frame_start && start_len == BEAT_W'(1)) ||
                     (beat && remain_q == BEAT_W'(1));
  assign end_size  = frame_start ? in_size : cur_size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q   <= '0;
      cur_size_q <= SIZE_W'(MIN_SIZE);
    end else if (frame_start) begin
      remain_q   <= start_len - BEAT_W'(1);
      cur_size_q <= in_size;
    end else if (beat) begin
      remain_q   <= remain_q - BEAT_W'(1);
    end
  end

  // R1
  end_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !frame_start) |=> !busy);

  // R5
  mid_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !in_valid) |=> busy);

endmodule

// File: rtl/shg_gap_timer.sv
module shg_gap_timer
  import shg_pkg::*;
#(
  parameter int M         = 1,
  parameter int MIN_SIZE  = 2,
  parameter int MAX_SIZE  = 6,
  parameter int BASE_LAT  = 5,
  parameter int STAGE_LAT = 3,
  parameter int SIZE_W    = 3,
  parameter int LAT_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last_beat,
  input  logic [SIZE_W-1:0] end_size,
  input  logic [LAT_W-1:0]  new_lat,
  output logic              gap_ok
);

  localparam int CAP   = max_gap(STAGE_LAT, MIN_SIZE, MAX_SIZE);
  localparam int ELP_W = $clog2(CAP + 1) + 1;

  logic [ELP_W-1:0]  elapsed_q;
  logic              has_prev_q;
  logic [SIZE_W-1:0] prev_size_q;
  logic [LAT_W-1:0]  prev_lat;
  logic [LAT_W-1:0]  need;

  shg_lat_table #(
    .M(M), .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE), .BASE_LAT(BASE_LAT),
    .STAGE_LAT(STAGE_LAT), .SIZE_W(SIZE_W), .LAT_W(LAT_W)
  ) u_prev_lat (
    .size_code(prev_size_q),
    .lat      (prev_lat)
  );

  assign need   = prev_lat - new_lat;
  assign gap_ok = !has_prev_q || (new_lat >= prev_lat) ||
                  (LAT_W'(elapsed_q) >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q   <= '0;
      has_prev_q  <= 1'b0;
      prev_size_q <= SIZE_W'(MIN_SIZE);
    end else if (last_beat) begin
      elapsed_q   <= '0;
      has_prev_q  <= 1'b1;
      prev_size_q <= end_size;
    end else if (elapsed_q < ELP_W'(CAP)) begin
      elapsed_q   <= elapsed_q + ELP_W'(1);
    end
  end

  // R3
  gap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    last_beat |=> (elapsed_q == '0) && has_prev_q);

  // R4
  gap_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!last_beat && elapsed_q < ELP_W'(CAP)) |=> (elapsed_q == $past(elapsed_q) + ELP_W'(1)));

endmodule

// File: rtl/shg_admission_guard.sv
module shg_admission_guard
  import shg_pkg::*;
#(
  parameter int M         = 1,
  parameter int MIN_SIZE  = 2,
  parameter int MAX_SIZE  = 6,
  parameter int BASE_LAT  = 5,
  parameter int STAGE_LAT = 3,
  parameter int SIZE_W    = $clog2(MAX_SIZE + 2),
  parameter int LAT_W     = $clog2(BASE_LAT + STAGE_LAT * (MAX_SIZE - M) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [SIZE_W-1:0] in_size,
  output logic              start_ok,
  output logic [LAT_W-1:0]  lat_out,
  output logic              hazard
);

  logic              in_range;
  logic              sop_seen;
  logic              frame_start;
  logic              busy;
  logic              last_beat;
  logic [SIZE_W-1:0] end_size;
  logic [LAT_W-1:0]  new_lat;
  logic              gap_ok;
  logic [LAT_W-1:0]  lat_q;
  logic              hazard_q;

  assign in_range    = (in_size >= SIZE_W'(MIN_SIZE)) && (in_size <= SIZE_W'(MAX_SIZE));
  assign sop_seen    = in_valid && in_sop;
  assign frame_start = sop_seen && in_range;

  shg_lat_table #(
    .M(M), .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE), .BASE_LAT(BASE_LAT),
    .STAGE_LAT(STAGE_LAT), .SIZE_W(SIZE_W), .LAT_W(LAT_W)
  ) u_new_lat (
    .size_code(in_size),
    .lat      (new_lat)
  );

  shg_frame_tracker #(
    .M(M), .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE), .SIZE_W(SIZE_W)
  ) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .frame_start(frame_start),
    .in_size    (in_size),
    .busy       (busy),
    .last_beat  (last_beat),
    .end_size   (end_size)
  );

  shg_gap_timer #(
    .M(M), .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE), .BASE_LAT(BASE_LAT),
    .STAGE_LAT(STAGE_LAT), .SIZE_W(SIZE_W), .LAT_W(LAT_W)
  ) u_gap (
    .clk      (clk),
    .rst      (rst),
    .last_beat(last_beat),
    .end_size (end_size),
    .new_lat  (new_lat),
    .gap_ok   (gap_ok)
  );

  assign start_ok = in_range && !busy && gap_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q    <= '0;
      hazard_q <= 1'b0;
    end else begin
      if (frame_start)           lat_q    <= new_lat;
      if (sop_seen && !start_ok) hazard_q <= 1'b1;
    end
  end

  assign lat_out = lat_q;
  assign hazard  = hazard_q;

  // R6
  hazard_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    hazard |=> hazard);

  // R6
  hazard_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && !start_ok) |=> hazard);

  // R2
  lat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_sop) |=> $stable(lat_out));

  // R7
  range_block_chk: assert property (@(posedge clk) disable iff (rst)
    !in_range |-> !start_ok);

endmodule

// File: tb/tb_shg_admission_guard.sv
module tb_shg_admission_guard;

  localparam int CLK_PERIOD = 10;
  localparam int M  = 1;
  localparam int MN = 2;
  localparam int MX = 6;
  localparam int BL = 5;
  localparam int SL = 3;
  localparam int SW = 3;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sop = 1'b0;
  logic [SW-1:0] in_size = '0;
  logic          start_ok;
  logic [LW-1:0] lat_out;
  logic          hazard;

  int checks = 0;
  int failures = 0;
  string cur_req = "R8";

  // reference model state
  int  m_rem, m_prev, m_cur, m_last, m_t, m_lat;
  bit  m_has, m_haz;

  always #(CLK_PERIOD/2) clk = ~clk;

  shg_admission_guard #(
    .M(M), .MIN_SIZE(MN), .MAX_SIZE(MX), .BASE_LAT(BL), .STAGE_LAT(SL),
    .SIZE_W(SW), .LAT_W(LW)
  ) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_size(in_size), .start_ok(start_ok), .lat_out(lat_out), .hazard(hazard)
  );

  function automatic int lat_of(input int s);
    return BL + SL * (s - M);
  endfunction

  function automatic bit model_ok(input int s);
    if (s < MN || s > MX) return 0;
    if (m_rem > 0) return 0;
    if (!m_has || s >= m_prev) return 1;
    return (m_t - m_last - 1) >= (lat_of(m_prev) - lat_of(s));
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rem = 0; m_prev = MN; m_cur = MN; m_last = 0; m_t = 0;
    m_lat = 0; m_has = 0; m_haz = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk(hazard, 0, "hazard after reset");
    chk(lat_out, 0, "lat_out after reset");
  endtask

  // one clock: drive at negedge, check combinational admit, then registered outputs
  task automatic cyc(input bit v, input bit s, input int sz);
    bit ok;
    bit last;
    in_valid = v; in_sop = s; in_size = SW'(sz);
    #1;
    ok = model_ok(sz);
    chk(start_ok, ok, "start_ok");
    @(posedge clk);
    last = 0;
    if (v && s && !ok) m_haz = 1;
    if (v && s && sz >= MN && sz <= MX) begin
      m_lat = lat_of(sz);
      m_cur = sz;
      m_rem = (1 << (sz - M)) - 1;
      if (m_rem == 0) last = 1;
    end else if (v && m_rem > 0) begin
      m_rem--;
      if (m_rem == 0) last = 1;
    end
    if (last) begin
      m_has = 1; m_prev = m_cur; m_last = m_t;
    end
    m_t++;
    @(negedge clk);
    chk(hazard, m_haz, "hazard");
    chk(lat_out, m_lat, "lat_out");
  endtask

  task automatic frame(input int sz);
    for (int i = 0; i < (1 << (sz - M)); i++) cyc(1, i == 0, sz);
  endtask

  task automatic idle(input int n, input int sz);
    for (int i = 0; i < n; i++) cyc(0, 0, sz);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    cur_req = "R8"; idle(2, 2);
    cur_req = "R9"; cyc(0, 1, 3); idle(1, 3);
    cur_req = "R1"; frame(4);
    cur_req = "R3"; frame(4); frame(6);
    cur_req = "R4"; idle(14, 2); frame(2);
    cur_req = "R3"; frame(3);
    cur_req = "R4"; frame(5); idle(6, 3); frame(3);
    cur_req = "R5"; frame(4);
    cur_req = "R2"; frame(6); frame(6);
    cur_req = "R6"; frame(6); cyc(1, 1, 2); cyc(1, 0, 2); idle(3, 2);
    cur_req = "R8"; do_reset(); idle(2, 4);
    cur_req = "R7"; frame(3); cyc(1, 1, 7); idle(2, 4); cyc(0, 0, 1);
    cur_req = "R8"; do_reset();
    cur_req = "R5"; cyc(1, 1, 3); cyc(1, 1, 3); idle(3, 3);
    finish_run();
  end

endmodule